// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Registered Status Flags

This block performs add, subtract, AND, OR and XOR on two operands. A mode input selects byte operation, which uses the low 8 bits of each operand, or word operation, which uses all 16 bits. The result is produced combinationally in the same cycle as the operands.

Five status flags are computed from the operation and its result: carry/borrow, parity, zero, sign and overflow. They are captured in a register on a rising clock edge, but only when a flag-write enable is high. Outside that, the register holds its value, so later steps can test the status of an earlier operation. Arithmetic and logic share one datapath. Two adder lanes, one for bytes and one for words, give each width its own carry-out and overflow.

Top module: `alu_status_unit`

## Requirements
- R1: With `op_sel` = 3'd0 (add), `result` is (A + B) modulo 2^width and carry is set exactly when the unsigned sum exceeds the width's maximum.
- R2: With `op_sel` = 3'd1 (subtract), `result` is (A - B) modulo 2^width and carry is set as a borrow exactly when A < B unsigned.
- R3: With `op_sel` = 3'd2, 3'd3 or 3'd4, `result` is A AND B, A OR B or A XOR B, and carry and overflow are cleared. Codes 3'd5 to 3'd7 give a zero result with carry and overflow cleared.
- R4: Overflow is set when an add or subtract result, read as two's complement, does not fit in the selected width.
- R5: Parity is set when bits 7:0 of the result hold an even number of ones, in both widths.
- R6: Zero is set when the result in the selected width equals zero.
- R7: Sign equals bit 15 of the result in word mode and bit 7 in byte mode.
- R8: With `word_mode` = 0, only bits 7:0 of each operand are used and `result[15:8]` is zero.
- R9: The flag outputs change only at a rising clock edge where `flag_wr` is 1. Otherwise they keep their value.
- R10: An active-low reset clears all five flags to 0.
- R11: In byte mode, FFh + 01h gives 00h with carry set, and 00h - 01h gives FFh with carry (borrow) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 3 | Operation code: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR |
| word_mode | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand (subtrahend) |
| flag_wr | input | 1 | Capture the flags at the next rising edge |
| result | output | 16 | Combinational result |
| flag_cf | output | 1 | Registered carry/borrow flag |
| flag_pf | output | 1 | Registered parity flag |
| flag_zf | output | 1 | Registered zero flag |
| flag_sf | output | 1 | Registered sign flag |
| flag_of | output | 1 | Registered overflow flag |

## Verification
`result` depends combinationally on the inputs in the same cycle. The bench therefore drives the inputs after a falling edge and compares the result a short delay later, before the next rising edge. The flags pass through one register. They are due just after the rising edge that follows an operation with `flag_wr` high, and the bench samples them one time unit after that edge. A behavioural model predicts them, and it holds its own copy of the flags whenever `flag_wr` is low, so that the hold cycles are checked too.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_SUB = 3'd1;
    localparam logic [2:0] OP_AND = 3'd2;
    localparam logic [2:0] OP_OR  = 3'd3;
    localparam logic [2:0] OP_XOR = 3'd4;

    typedef struct packed {
        logic cf;
        logic pf;
        logic zf;
        logic sf;
        logic of;
    } status_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W:0]   ext;
    logic [W-1:0] b_eff;

    always_comb begin
        ext   = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        b_eff = sub ? ~b : b;
        sum   = ext[W-1:0];
        carry = ext[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (ext[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    output logic [W-1:0] res
);
    import alu_flags_pkg::*;

    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_status_gen.sv
module alu_status_gen #(
    parameter int W     = 16,
    parameter int PAR_W = 8
) (
    input  logic [W-1:0] res,
    input  logic         word_mode,
    output logic         pf,
    output logic         zf,
    output logic         sf
);
    localparam int HALF = W / 2;

    always_comb begin
        pf = ~^res[PAR_W-1:0];
        zf = (res == '0);
        sf = word_mode ? res[W-1] : res[HALF-1];
    end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              flag_wr,
    output logic [DATA_W-1:0] result,
    output logic              flag_cf,
    output logic              flag_pf,
    output logic              flag_zf,
    output logic              flag_sf,
    output logic              flag_of
);
    import alu_flags_pkg::*;

    localparam int BYTE_W = DATA_W / 2;
    localparam int LANES  = 2;

    typedef struct packed {
        status_t flags;
    } state_t;

    state_t state_d, state_q;

    logic [DATA_W-1:0] lane_sum [LANES];
    logic              lane_c   [LANES];
    logic              lane_o   [LANES];
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] res_d;
    logic              is_sub;
    logic              pf_w, zf_w, sf_w;

    assign is_sub = (op_sel == OP_SUB);

    // lane 0: byte width, lane 1: word width
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? BYTE_W : DATA_W;
        logic [LW-1:0] s_w;
        alu_arith #(.W(LW)) u_arith (
            .a    (opnd_a[LW-1:0]),
            .b    (opnd_b[LW-1:0]),
            .sub  (is_sub),
            .sum  (s_w),
            .carry(lane_c[g]),
            .ovf  (lane_o[g])
        );
        assign lane_sum[g] = DATA_W'(s_w);
    end

    alu_logic #(.W(DATA_W)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .op (op_sel),
        .res(logic_res)
    );

    alu_status_gen #(.W(DATA_W), .PAR_W(BYTE_W)) u_status (
        .res      (res_d),
        .word_mode(word_mode),
        .pf       (pf_w),
        .zf       (zf_w),
        .sf       (sf_w)
    );

    always_comb begin
        status_t nf;
        nf    = '0;
        res_d = '0;
        case (op_sel)
            OP_ADD, OP_SUB: begin
                res_d = lane_sum[word_mode];
                nf.cf = lane_c[word_mode];
                nf.of = lane_o[word_mode];
            end
            default: begin
                res_d = word_mode ? logic_res
                                  : {{BYTE_W{1'b0}}, logic_res[BYTE_W-1:0]};
            end
        endcase
        nf.pf   = pf_w;
        nf.zf   = zf_w;
        nf.sf   = sf_w;
        state_d = state_q;
        if (flag_wr) state_d.flags = nf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result  = res_d;
    assign flag_cf = state_q.flags.cf;
    assign flag_pf = state_q.flags.pf;
    assign flag_zf = state_q.flags.zf;
    assign flag_sf = state_q.flags.sf;
    assign flag_of = state_q.flags.of;

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> $stable({flag_cf, flag_pf, flag_zf, flag_sf, flag_of}));

    assert_logic_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && op_sel != OP_ADD && op_sel != OP_SUB) |=> (!flag_cf && !flag_of));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> (flag_zf == ($past(result) == '0)));

    assert_sign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> (flag_sf == ($past(word_mode) ? $past(result[DATA_W-1])
                                                  : $past(result[BYTE_W-1]))));

    assert_parity_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> (flag_pf == ~^$past(result[BYTE_W-1:0])));

    assert_byte_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_mode |-> (result[DATA_W-1:BYTE_W] == '0));
endmodule

// File: tb/test_alu_status_unit.sv
module test_alu_status_unit;
    localparam int PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  op_sel = 0;
    logic        word_mode = 0;
    logic [15:0] opnd_a = 0, opnd_b = 0;
    logic        flag_wr = 0;
    logic [15:0] result;
    logic        flag_cf, flag_pf, flag_zf, flag_sf, flag_of;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [4:0] exp_flags = 5'b0; // {cf,pf,zf,sf,of}

    always #(PERIOD/2) clk = ~clk;

    alu_status_unit i_alu_status_unit (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .word_mode(word_mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_wr(flag_wr), .result(result),
        .flag_cf(flag_cf), .flag_pf(flag_pf), .flag_zf(flag_zf),
        .flag_sf(flag_sf), .flag_of(flag_of)
    );

    task automatic model(input logic [2:0] op, input logic wm,
                         input logic [15:0] a, input logic [15:0] b,
                         output logic [15:0] r, output logic [4:0] f);
        int mask, half, ua, ub, sa, sb, full, ss, ones;
        logic c, o;
        mask = wm ? 32'hFFFF : 32'hFF;
        half = wm ? 32768 : 128;
        ua = int'(a) & mask;
        ub = int'(b) & mask;
        sa = (ua >= half) ? ua - 2*half : ua;
        sb = (ub >= half) ? ub - 2*half : ub;
        c = 0; o = 0; full = 0;
        case (op)
            3'd0: begin full = ua + ub; c = (full > mask); ss = sa + sb;
                        o = (ss >= half) || (ss < -half); end
            3'd1: begin full = ua - ub; c = (ua < ub); ss = sa - sb;
                        o = (ss >= half) || (ss < -half); end
            3'd2: full = ua & ub;
            3'd3: full = ua | ub;
            3'd4: full = ua ^ ub;
            default: full = 0;
        endcase
        r = 16'(full & mask);
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(r[i]);
        f = {c, (ones % 2) == 0, r == 16'h0, wm ? r[15] : r[7], o};
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [2:0] op, input logic wm,
                        input logic [15:0] a, input logic [15:0] b, input logic wr);
        logic [15:0] er;
        logic [4:0]  ef;
        @(negedge clk);
        op_sel = op; word_mode = wm; opnd_a = a; opnd_b = b; flag_wr = wr;
        model(op, wm, a, b, er, ef);
        #1;
        check({tag, " result"}, 32'(result), 32'(er));
        if (wr) exp_flags = ef;
        @(posedge clk);
        #1;
        check({tag, " flags"}, 32'({flag_cf, flag_pf, flag_zf, flag_sf, flag_of}),
              32'(exp_flags));
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R10 reset flags", 32'({flag_cf, flag_pf, flag_zf, flag_sf, flag_of}), 32'h0);
        @(negedge clk);
        rst_n = 1;
        // R11 byte corners
        step("R11 add FF+1", 3'd0, 0, 16'h00FF, 16'h0001, 1);
        step("R11 sub 0-1",  3'd1, 0, 16'h0000, 16'h0001, 1);
        // R1 / R2 word
        step("R1 word add carry", 3'd0, 1, 16'hFFFF, 16'h0002, 1);
        step("R2 word sub", 3'd1, 1, 16'h1234, 16'h0234, 1);
        // R4 overflow
        step("R4 byte add ovf", 3'd0, 0, 16'h007F, 16'h0001, 1);
        step("R4 byte sub ovf", 3'd1, 0, 16'h0080, 16'h000F, 1);
        step("R4 word add ovf", 3'd0, 1, 16'h7FFF, 16'h0001, 1);
        step("R4 word sub ovf", 3'd1, 1, 16'h8000, 16'h0001, 1);
        // R3 logic clears carry/ovf after a carry
        step("R3 pre carry", 3'd0, 1, 16'hFFFF, 16'hFFFF, 1);
        step("R3 and", 3'd2, 1, 16'hF0F0, 16'h3C3C, 1);
        step("R3 or",  3'd3, 1, 16'h8000, 16'h0001, 1);
        step("R3 xor", 3'd4, 0, 16'h12AA, 16'h3455, 1);
        step("R3 code5", 3'd5, 1, 16'hFFFF, 16'hFFFF, 1);
        step("R3 code7", 3'd7, 0, 16'h00FF, 16'h00FF, 1);
        // R5 parity on low byte only in word mode
        step("R5 parity", 3'd3, 1, 16'h0100, 16'h0003, 1);
        step("R5 parity odd", 3'd3, 1, 16'hFF00, 16'h0001, 1);
        // R6 zero / R7 sign in each width
        step("R6 zero byte", 3'd1, 0, 16'hAB55, 16'hCD55, 1);
        step("R7 sign byte", 3'd0, 0, 16'h0040, 16'h0040, 1);
        step("R7 sign word", 3'd0, 1, 16'h0040, 16'h0040, 1);
        // R8 upper operand bytes ignored in byte mode
        step("R8 byte ignore upper", 3'd0, 0, 16'hFF10, 16'hEE20, 1);
        // R9 hold when flag_wr low
        step("R9 set", 3'd0, 0, 16'h00FF, 16'h0001, 1);
        step("R9 hold1", 3'd1, 1, 16'h0005, 16'h0003, 0);
        step("R9 hold2", 3'd4, 0, 16'h0011, 16'h0011, 0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            op = 3'($urandom % 8);
            step("R1 R2 R3 R4 random", op, 1'($urandom), 16'($urandom),
                 16'($urandom), 1'($urandom));
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule